// File: doc/BRIEF.md
# Register file with pointer-based indirect access

This block is the data register file of a small processor datapath. Every access names a 7-bit direct address, and two bank-select bits extend it to a 9-bit location. Two addresses in each bank are special. Offset 04h holds an 8-bit pointer register. Offset 00h is a virtual register that has no storage of its own.

An access to offset 00h is redirected to the 9-bit location formed from one indirect-bank bit (the MSB) and the pointer. Walking a table therefore takes a loop of indirect accesses and pointer increments, with no address arithmetic in the instruction stream. When an access resolves through the pointer, the block raises a flag so that the status logic can still update its flags on writes that store nothing.

When the pointer selects the virtual register itself, a read returns zero and a write is dropped. This applies when pointer bits 6:0 are zero, in either indirect bank. Storage writes on the clock edge. Reads are combinational.

Top module: `regfile_indirect`

## Requirements
- R1: After reset the pointer is 00h. Reading offset 00h therefore returns 00h, and reading offset 04h returns 00h.
- R2: A direct write to offset A (A not 00h or 04h) with bank bits B stores at location {B,A}. Writes to the same offset in different banks are separate locations. A later read of {B,A} returns the stored byte.
- R3: The pointer appears at offset 04h in all four banks. A write through any bank is read back through any other bank.
- R4: A read of offset 00h returns the byte at location {ibank_i, pointer}. The direct bank bits have no effect on it.
- R5: A write to offset 00h stores wdata_i at location {ibank_i, pointer}. A direct read of that location returns it.
- R6: When pointer bits 6:0 are zero, a read of offset 00h returns 00h for either value of ibank_i.
- R7: When pointer bits 6:0 are zero, a write to offset 00h changes neither the pointer nor any storage location.
- R8: indirect_o is 1 exactly when rd_i or wr_i is 1 and dir_addr_i is 00h.
- R9: When the pointer holds 04h, an access to offset 00h reaches the pointer register itself.
- R10: rdata_o is 00h whenever rd_i is 0.
- R11: Locations 20h to 2Fh of bank 0 can be cleared by repeating two steps: an indirect write of 00h, then a pointer increment. A neighbouring location is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_addr_i | input | 7 | Direct address within a bank |
| bank_i | input | 2 | Bank bits for direct accesses (location bits 8:7) |
| ibank_i | input | 1 | Bank bit for indirect accesses (location bit 8) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, committed on the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| indirect_o | output | 1 | Access resolved through the pointer |

## Verification
Two functions can fall on the same access. The first is address substitution through the pointer. The second is the case where the pointer names either the virtual register or the pointer register itself.

The bench provokes both overlaps by loading the pointer with 00h, 80h or 04h and then issuing indirect reads and writes. It judges the outcome at the ports. It reads back the pointer and neighbouring locations after a discarded write, and reads offset 04h after a self-referencing write. It also checks the indirect flag on every one of these cases.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int DATA_W = 8;
  localparam int DIR_W  = 7;
  localparam int BANK_W = 2;
  localparam int PTR_W  = 8;
  localparam int FULL_W = DIR_W + BANK_W;
  localparam logic [DIR_W-1:0] VIRT_OFS = 7'h00;
  localparam logic [DIR_W-1:0] PTR_OFS  = 7'h04;

  typedef enum logic [1:0] {
    TGT_VIRT = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_RAM  = 2'd2
  } tgt_e;
endpackage

// File: rtl/rfi_addr_resolve.sv
module rfi_addr_resolve
  import rfi_pkg::*;
#(
  parameter int DIR_WP  = DIR_W,
  parameter int BANK_WP = BANK_W,
  parameter int PTR_WP  = PTR_W,
  localparam int FULL_WP = DIR_WP + BANK_WP,
  localparam int IBANK_W = FULL_WP - PTR_WP
) (
  input  logic [DIR_WP-1:0]  dir_addr_i,
  input  logic [BANK_WP-1:0] bank_i,
  input  logic [IBANK_W-1:0] ibank_i,
  input  logic [PTR_WP-1:0]  ptr_i,
  output logic [FULL_WP-1:0] full_addr_o,
  output tgt_e               tgt_o,
  output logic               ind_o
);
  always_comb begin
    ind_o       = (dir_addr_i == VIRT_OFS);
    full_addr_o = ind_o ? {ibank_i, ptr_i} : {bank_i, dir_addr_i};
    // mirrored specials decode on the in-bank offset only
    if (full_addr_o[DIR_WP-1:0] == VIRT_OFS)     tgt_o = TGT_VIRT;
    else if (full_addr_o[DIR_WP-1:0] == PTR_OFS) tgt_o = TGT_PTR;
    else                                         tgt_o = TGT_RAM;
  end
endmodule

// File: rtl/rfi_ptr_reg.sv
module rfi_ptr_reg
  import rfi_pkg::*;
#(
  parameter int PTR_WP = PTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_WP-1:0] wdata_i,
  output logic [PTR_WP-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= '0;
    else if (we_i) ptr_o <= wdata_i;
  end

  assert_ptr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ptr_o));
endmodule

// File: rtl/rfi_store.sv
module rfi_store
  import rfi_pkg::*;
#(
  parameter int ADDR_WP = FULL_W,
  parameter int DATA_WP = DATA_W,
  localparam int DEPTH  = 1 << ADDR_WP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_WP-1:0] addr_i,
  input  logic [DATA_WP-1:0] wdata_i,
  output logic [DATA_WP-1:0] rdata_o
);
  logic [DATA_WP-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  // virtual and pointer offsets never reach storage (R7, R9)
  assert_store_skip_specials_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (addr_i[DIR_W-1:0] != VIRT_OFS) && (addr_i[DIR_W-1:0] != PTR_OFS));
endmodule

// File: rtl/regfile_indirect.sv
module regfile_indirect
  import rfi_pkg::*;
#(
  parameter int DATA_WP = DATA_W,
  parameter int DIR_WP  = DIR_W,
  parameter int BANK_WP = BANK_W,
  parameter int PTR_WP  = PTR_W,
  localparam int FULL_WP = DIR_WP + BANK_WP,
  localparam int IBANK_W = FULL_WP - PTR_WP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIR_WP-1:0]  dir_addr_i,
  input  logic [BANK_WP-1:0] bank_i,
  input  logic [IBANK_W-1:0] ibank_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DATA_WP-1:0] wdata_i,
  output logic [DATA_WP-1:0] rdata_o,
  output logic               indirect_o
);
  logic [FULL_WP-1:0] full_addr;
  logic [PTR_WP-1:0]  ptr_q;
  logic [DATA_WP-1:0] store_rdata;
  logic               ind;
  tgt_e               tgt;

  rfi_addr_resolve #(
    .DIR_WP (DIR_WP),
    .BANK_WP(BANK_WP),
    .PTR_WP (PTR_WP)
  ) i_resolve (
    .dir_addr_i (dir_addr_i),
    .bank_i     (bank_i),
    .ibank_i    (ibank_i),
    .ptr_i      (ptr_q),
    .full_addr_o(full_addr),
    .tgt_o      (tgt),
    .ind_o      (ind)
  );

  rfi_ptr_reg #(.PTR_WP(PTR_WP)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i && (tgt == TGT_PTR)),
    .wdata_i(wdata_i[PTR_WP-1:0]),
    .ptr_o  (ptr_q)
  );

  rfi_store #(.ADDR_WP(FULL_WP), .DATA_WP(DATA_WP)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_i && (tgt == TGT_RAM)),
    .addr_i (full_addr),
    .wdata_i(wdata_i),
    .rdata_o(store_rdata)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (tgt)
        TGT_PTR: rdata_o = DATA_WP'(ptr_q);
        TGT_RAM: rdata_o = store_rdata;
        default: rdata_o = '0;
      endcase
    end
  end

  assign indirect_o = ind && (rd_i || wr_i);

  assert_flag_needs_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    indirect_o |-> (rd_i || wr_i) && (dir_addr_i == VIRT_OFS));

  assert_idle_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));

  assert_virtual_read_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && indirect_o && (ptr_q[DIR_WP-1:0] == VIRT_OFS)) |-> (rdata_o == '0));

  assert_self_write_loads_ptr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && indirect_o && (ptr_q[DIR_WP-1:0] == PTR_OFS)) |=> (ptr_q == $past(wdata_i[PTR_WP-1:0])));
endmodule

// File: tb/test_regfile_indirect.sv
module test_regfile_indirect;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] dir_addr_i = '0;
  logic [1:0] bank_i = '0;
  logic       ibank_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       indirect_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  regfile_indirect i_regfile_indirect (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_addr_i(dir_addr_i), .bank_i(bank_i),
    .ibank_i(ibank_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .indirect_o(indirect_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] b, logic ib, logic [6:0] a, logic [7:0] d);
    @(negedge clk_i);
    bank_i = b; ibank_i = ib; dir_addr_i = a; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] b, logic ib, logic [6:0] a, output logic [7:0] d, output logic f);
    @(negedge clk_i);
    bank_i = b; ibank_i = ib; dir_addr_i = a; rd_i = 1'b1; wr_i = 1'b0;
    #1;
    d = rdata_o; f = indirect_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic f;
    rd(2'd0, 1'b0, 7'h00, d, f);
    check("R1 virtual after reset", d, 8'h00);
    check("R8 flag on indirect read", {7'd0, f}, 8'h01);
    rd(2'd3, 1'b0, 7'h04, d, f);
    check("R1 pointer after reset", d, 8'h00);
    check("R8 flag off on direct read", {7'd0, f}, 8'h00);
  endtask

  task automatic t_direct();
    logic [7:0] d; logic f;
    wr(2'd0, 1'b0, 7'h20, 8'hA5);
    wr(2'd1, 1'b0, 7'h20, 8'h5A);
    wr(2'd3, 1'b0, 7'h7F, 8'h3C);
    rd(2'd0, 1'b0, 7'h20, d, f); check("R2 bank0 20h", d, 8'hA5);
    rd(2'd1, 1'b0, 7'h20, d, f); check("R2 bank1 20h", d, 8'h5A);
    rd(2'd3, 1'b0, 7'h7F, d, f); check("R2 bank3 7Fh", d, 8'h3C);
  endtask

  task automatic t_ptr_mirror();
    logic [7:0] d; logic f;
    wr(2'd2, 1'b0, 7'h04, 8'h20);
    rd(2'd1, 1'b0, 7'h04, d, f); check("R3 pointer via bank1", d, 8'h20);
    rd(2'd3, 1'b1, 7'h04, d, f); check("R3 pointer via bank3", d, 8'h20);
  endtask

  task automatic t_ind_read();
    logic [7:0] d; logic f;
    rd(2'd3, 1'b0, 7'h00, d, f); check("R4 indirect read 020h", d, 8'hA5);
    wr(2'd0, 1'b0, 7'h04, 8'hA0);
    rd(2'd2, 1'b0, 7'h00, d, f); check("R4 indirect read 0A0h", d, 8'h5A);
  endtask

  task automatic t_ind_write();
    logic [7:0] d; logic f;
    wr(2'd0, 1'b0, 7'h04, 8'h30);
    wr(2'd0, 1'b1, 7'h00, 8'h77);
    rd(2'd2, 1'b0, 7'h30, d, f); check("R5 indirect write to 130h", d, 8'h77);
  endtask

  task automatic t_ptr_zero();
    logic [7:0] d; logic f;
    wr(2'd0, 1'b0, 7'h04, 8'h00);
    wr(2'd0, 1'b0, 7'h00, 8'hFF);
    rd(2'd0, 1'b0, 7'h04, d, f); check("R7 pointer kept after dropped write", d, 8'h00);
    rd(2'd0, 1'b0, 7'h20, d, f); check("R7 bank0 20h kept", d, 8'hA5);
    rd(2'd3, 1'b0, 7'h7F, d, f); check("R7 bank3 7Fh kept", d, 8'h3C);
    rd(2'd0, 1'b0, 7'h00, d, f); check("R6 read with pointer 00h", d, 8'h00);
    wr(2'd0, 1'b0, 7'h04, 8'h80);
    rd(2'd0, 1'b1, 7'h00, d, f); check("R6 read with pointer 80h ibank1", d, 8'h00);
    check("R8 flag with pointer at virtual", {7'd0, f}, 8'h01);
  endtask

  task automatic t_self_ptr();
    logic [7:0] d; logic f;
    wr(2'd0, 1'b0, 7'h04, 8'h04);
    wr(2'd1, 1'b0, 7'h00, 8'h55);
    rd(2'd0, 1'b0, 7'h04, d, f); check("R9 write through pointer 04h", d, 8'h55);
  endtask

  task automatic t_flag_idle();
    @(negedge clk_i);
    dir_addr_i = 7'h00; rd_i = 1'b0; wr_i = 1'b0; #1;
    check("R8 no strobe no flag", {7'd0, indirect_o}, 8'h00);
    dir_addr_i = 7'h05; rd_i = 1'b1; #1;
    check("R8 direct read no flag", {7'd0, indirect_o}, 8'h00);
    dir_addr_i = 7'h04; rd_i = 1'b0; #1;
    check("R10 idle read zero", rdata_o, 8'h00);
    dir_addr_i = 7'h00; wdata_i = 8'h00; wr_i = 1'b0; #1;
    check("R8 no strobe on 00h", {7'd0, indirect_o}, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] d; logic f;
    for (int i = 0; i < 16; i++) wr(2'd0, 1'b0, 7'(8'h20 + i), 8'(8'hC0 + i));
    wr(2'd0, 1'b0, 7'h30, 8'h99);
    wr(2'd0, 1'b0, 7'h04, 8'h20);
    for (int i = 0; i < 16; i++) begin
      wr(2'd0, 1'b0, 7'h00, 8'h00);
      rd(2'd0, 1'b0, 7'h04, d, f);
      wr(2'd0, 1'b0, 7'h04, d + 8'h01);
    end
    for (int i = 0; i < 16; i++) begin
      rd(2'd0, 1'b0, 7'(8'h20 + i), d, f);
      check("R11 cleared location", d, 8'h00);
    end
    rd(2'd0, 1'b0, 7'h30, d, f); check("R11 neighbour 30h kept", d, 8'h99);
    rd(2'd0, 1'b0, 7'h04, d, f); check("R11 pointer after loop", d, 8'h30);
  endtask

  initial begin
    #1;
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;
    t_reset();
    t_direct();
    t_ptr_mirror();
    t_ind_read();
    t_ind_write();
    t_ptr_zero();
    t_self_ptr();
    t_flag_idle();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule